// File: doc/BRIEF.md
# Priority-Escalating Output Arbiter

This block sits at one output of a crossbar and decides which of several input controllers may use that output in the current flit cycle. Each requester raises a request and tags it with a two-bit priority. Two of the priority values are user classes and the third is a system class. The requester with the highest effective class always wins. When several requesters share the highest class, a free-running 16-bit LFSR picks the winner. The LFSR sets a rotating start point for a circular scan over the requesters.

A requester that keeps losing does not starve. A small state machine per requester counts its consecutive losses. Once the count reaches the promotion limit (seven by default), the request competes at system class until it wins or is withdrawn. A loser simply keeps its request up and tries again in the next cycle. The grant is combinational from the current requests and the registered tracker state, so a request can win in the cycle it first appears.

Each tracker has three states. In `TRK_IDLE` the requester has no pending losses. In `TRK_CONTEND` it has lost at least once and is still below the limit. In `TRK_PROMOTED` it has reached the limit. The transitions are as follows:
- Idle→Contend on the first loss.
- Contend→Contend on each further loss below the limit.
- Contend→Promoted (or Idle→Promoted when the limit is 1) on the loss that reaches the limit.
- Promoted→Promoted on a further loss.
- Any state→Idle on a grant or a dropped request.

Top module: `prio_esc_arbiter`

## Requirements
- R1: The grant vector is one-hot or all-zero, and it is all-zero exactly in the cycles where no request is raised.
- R2: A grant bit is set only for a requester whose request bit is high in that cycle.
- R3: Priority field per requester: 2'b00 is user-low, 2'b01 is user-high, and 2'b10 or 2'b11 is system. The winner's effective class is never below that of any other active requester.
- R4: Each cycle in which a requester requests and is not granted adds one to its loss count. After seven such consecutive losses, its effective class is system from the next cycle on.
- R5: A requester's loss count returns to zero in any cycle in which it is granted or its request is low. A re-raised request therefore starts again at its own class.
- R6: Among requesters tied at the top class, the winner is picked by a scan that starts at an index taken from a 16-bit LFSR advanced every cycle. Over a long run of a persistent tie, every tied requester wins repeatedly.
- R7: Reset clears all loss counts, and the grant is all-zero while no request is raised.
- R8: A promoted user-low requester beats a user-high requester that is not promoted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_REQ | Request bit per requester |
| prio_i | input | 2*NUM_REQ | Priority field per requester, requester i in bits [2i+1:2i] |
| gnt_o | output | NUM_REQ | One-hot grant, all-zero when idle |

## Verification
A tracker stuck in the wrong state changes who wins in a way that shows at the ports. Suppose it fails to count a loss, or clears too late after a win or a drop. The promotion of a low requester against a high one then comes one or more cycles early or late. That mismatch is visible at the eighth cycle of a two-requester contest. A broken tie rule shows up within a few hundred cycles of a persistent system-level tie as a requester that never wins. A wrong class comparison is seen in the first cycle where two classes meet.

// File: rtl/esc_arb_pkg.sv
package esc_arb_pkg;

    localparam int LVL_W = 2;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_SYS  = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        TRK_IDLE     = 2'd0,
        TRK_CONTEND  = 2'd1,
        TRK_PROMOTED = 2'd2
    } trk_state_e;

    // Priority field decode: bit 1 set means system class.
    function automatic level_e prio_to_level(input logic [LVL_W-1:0] p);
        if (p[1])      return LVL_SYS;
        else if (p[0]) return LVL_HIGH;
        else           return LVL_LOW;
    endfunction

endpackage

// File: rtl/esc_lfsr.sv
module esc_lfsr #(
    parameter int             W     = 16,
    parameter logic [W-1:0]   TAPS  = 16'hB400,
    parameter logic [W-1:0]   SEED  = 16'hACE1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;

    always_comb begin
        state_d = {1'b0, state_q[W-1:1]};
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= SEED;
        else         state_q <= state_d;
    end

    assign state_o = state_q;

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);

    // R6
    lfsr_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> state_q != $past(state_q));

endmodule

// File: rtl/esc_req_tracker.sv
module esc_req_tracker
    import esc_arb_pkg::*;
#(
    parameter  int PROMOTE_AFTER = 7,
    localparam int CNT_W         = $clog2(PROMOTE_AFTER + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             gnt_i,
    input  logic [LVL_W-1:0] prio_i,
    output logic [LVL_W-1:0] lvl_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PROMOTE_AFTER);

    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lost;

    assign lost = req_i && !gnt_i;

    // Next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRK_IDLE, TRK_CONTEND: begin
                if (!lost) begin
                    state_d = TRK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = (cnt_d == LIMIT) ? TRK_PROMOTED : TRK_CONTEND;
                end
            end
            TRK_PROMOTED: begin
                if (!lost) begin
                    state_d = TRK_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TRK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            TRK_PROMOTED: lvl_o = LVL_SYS;
            default:      lvl_o = prio_to_level(prio_i);
        endcase
    end

    // R5
    clear_on_win_or_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lost |=> (state_q == TRK_IDLE && cnt_q == '0));

    // R4
    promote_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lost && state_q != TRK_PROMOTED && cnt_q == LIMIT - 1'b1) |=> state_q == TRK_PROMOTED);

    // R4
    loss_counts_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lost && state_q != TRK_PROMOTED) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/esc_pick.sv
module esc_pick #(
    parameter  int NUM_REQ = 4,
    parameter  int LVL_W   = 2,
    localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0]            req_i,
    input  logic [NUM_REQ-1:0][LVL_W-1:0] lvl_i,
    input  logic [IDX_W-1:0]              start_i,
    output logic [NUM_REQ-1:0]            gnt_o
);

    logic [LVL_W-1:0] top_lvl;

    // Highest class among active requesters
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_i[i] && lvl_i[i] > top_lvl) begin
                top_lvl = lvl_i[i];
            end
        end
    end

    // Circular scan from the start index; first match at the top class wins
    always_comb begin
        int  idx;
        logic found;
        gnt_o = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < NUM_REQ; k++) begin
            idx = int'(start_i) + k;
            if (idx >= NUM_REQ) idx = idx - NUM_REQ;
            if (!found && req_i[idx] && lvl_i[idx] == top_lvl) begin
                gnt_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_esc_arbiter.sv
module prio_esc_arbiter
    import esc_arb_pkg::*;
#(
    parameter  int                  NUM_REQ       = 4,
    parameter  int                  PROMOTE_AFTER = 7,
    parameter  int                  LFSR_W        = 16,
    parameter  logic [LFSR_W-1:0]   LFSR_TAPS     = 16'hB400,
    parameter  logic [LFSR_W-1:0]   LFSR_SEED     = 16'hACE1,
    localparam int                  IDX_W         = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_REQ-1:0]         req_i,
    input  logic [NUM_REQ*LVL_W-1:0]   prio_i,
    output logic [NUM_REQ-1:0]         gnt_o
);

    logic [LFSR_W-1:0]             lfsr;
    logic [IDX_W-1:0]              start;
    logic [NUM_REQ-1:0][LVL_W-1:0] lvl;
    logic [NUM_REQ-1:0]            gnt;

    esc_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_o (lfsr)
    );

    assign start = IDX_W'(lfsr % LFSR_W'(NUM_REQ));

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_trk
        esc_req_tracker #(
            .PROMOTE_AFTER (PROMOTE_AFTER)
        ) u_trk (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (req_i[g]),
            .gnt_i  (gnt[g]),
            .prio_i (prio_i[g*LVL_W +: LVL_W]),
            .lvl_o  (lvl[g])
        );
    end

    esc_pick #(
        .NUM_REQ (NUM_REQ),
        .LVL_W   (LVL_W)
    ) u_pick (
        .req_i   (req_i),
        .lvl_i   (lvl),
        .start_i (start),
        .gnt_o   (gnt)
    );

    assign gnt_o = gnt;

    // R1
    gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    // R1
    gnt_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |-> (gnt_o != '0));

    // R2
    gnt_only_requester_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o & ~req_i) == '0);

    // R3
    for (genvar w = 0; w < NUM_REQ; w++) begin : g_prio_w
        for (genvar o = 0; o < NUM_REQ; o++) begin : g_prio_o
            if (w != o) begin : g_pair
                class_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (gnt_o[w] && req_i[o]) |-> (lvl[o] <= lvl[w]));
            end
        end
    end

endmodule

// File: tb/tb_prio_esc_arbiter.sv
`timescale 1ns/1ps
module tb_prio_esc_arbiter;

    localparam int N     = 4;
    localparam int LIMIT = 7;
    localparam logic [1:0] LO = 2'b00;
    localparam logic [1:0] HI = 2'b01;
    localparam logic [1:0] SY = 2'b10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [2*N-1:0] prio = '0;
    logic [N-1:0]   gnt;

    int checks = 0;
    int errors = 0;
    int cnt [N];
    int wins [N];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_esc_arbiter #(.NUM_REQ(N), .PROMOTE_AFTER(LIMIT)) dut (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .req_i  (req),
        .prio_i (prio),
        .gnt_o  (gnt)
    );

    function automatic logic [2*N-1:0] pk(input logic [1:0] a, input logic [1:0] b,
                                          input logic [1:0] c, input logic [1:0] d);
        return {d, c, b, a};
    endfunction

    function automatic int cls(input logic [1:0] p, input int c);
        if (c >= LIMIT) return 2;
        if (p[1]) return 2;
        if (p[0]) return 1;
        return 0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One arbitration cycle: drive, check against the model, advance the model.
    task automatic step(input logic [N-1:0] r, input logic [2*N-1:0] p,
                        input bit use_exp, input logic [N-1:0] exp_g, input string tag);
        logic [N-1:0] g;
        int maxl;
        @(negedge clk);
        req = r; prio = p;
        #1;
        g = gnt;
        maxl = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && cls(p[2*i +: 2], cnt[i]) > maxl) maxl = cls(p[2*i +: 2], cnt[i]);
        check($onehot0(g) && ((r != 0) == (g != 0)), "R1 onehot/idle", g, r);
        check((g & ~r) == 0, "R2 grant to requester", g, r);
        for (int i = 0; i < N; i++)
            if (g[i]) begin
                check(cls(p[2*i +: 2], cnt[i]) == maxl, "R3 top class wins", g, r);
                wins[i]++;
            end
        if (use_exp) check(g == exp_g, tag, g, exp_g);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (!r[i] || g[i]) cnt[i] = 0;
            else if (cnt[i] < LIMIT) cnt[i]++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; prio = '0;
        repeat (3) @(negedge clk);
        #1;
        check(gnt == '0, "R7 reset grant idle", gnt, '0);
        for (int i = 0; i < N; i++) cnt[i] = 0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < N; i++) begin cnt[i] = 0; wins[i] = 0; end
        do_reset();

        // R1 idle cycle
        step('0, '0, 1, 4'b0000, "R1 no request no grant");

        // R3 class order on first contact
        step(4'b0111, pk(LO, HI, SY, LO), 1, 4'b0100, "R3 system beats users");
        step(4'b0000, '0, 1, 4'b0000, "R1 idle");
        step(4'b0011, pk(HI, LO, LO, LO), 1, 4'b0001, "R3 high beats low");
        step(4'b0000, '0, 1, 4'b0000, "R1 idle");

        // R4 / R8: low requester promoted after seven losses
        for (int c = 0; c < LIMIT; c++)
            step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R4 high wins before promotion");
        step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0001, "R8 promoted low beats high");
        step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R5 count cleared after win");
        step(4'b0000, '0, 1, 4'b0000, "R1 idle");

        // R5: a dropped request restarts its count
        for (int c = 0; c < 5; c++)
            step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R5 pre-drop losses");
        step(4'b0010, pk(LO, HI, LO, LO), 1, 4'b0010, "R5 drop cycle");
        for (int c = 0; c < LIMIT; c++)
            step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R5 restarted count");
        step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0001, "R5 promotion after full seven");
        step(4'b0000, '0, 1, 4'b0000, "R1 idle");

        // R7: reset in the middle of a losing streak clears counts
        for (int c = 0; c < 5; c++)
            step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R7 pre-reset losses");
        do_reset();
        for (int c = 0; c < LIMIT; c++)
            step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0010, "R7 counts cleared by reset");
        step(4'b0011, pk(LO, HI, LO, LO), 1, 4'b0001, "R7 promotion after reset");
        step(4'b0000, '0, 1, 4'b0000, "R1 idle");

        // R6: persistent system-level tie, every requester must keep winning
        for (int i = 0; i < N; i++) wins[i] = 0;
        for (int c = 0; c < 400; c++)
            step(4'b1111, pk(SY, SY, 2'b11, SY), 0, '0, "");
        for (int i = 0; i < N; i++)
            check(wins[i] >= 20, "R6 tie spread", 4'(wins[i] > 15 ? 15 : wins[i]), 4'd15);

        // Constrained random traffic checked against the model
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0]   r;
            logic [2*N-1:0] p;
            r = N'($urandom_range(0, (1 << N) - 1));
            if ($urandom_range(0, 9) == 0) r = '0;
            p = (2*N)'($urandom);
            for (int i = 0; i < N; i++)
                if ($urandom_range(0, 3) != 0) p[2*i+1] = 1'b0;
            step(r, p, 0, '0, "");
        end

        summary();
    end

endmodule